// File: doc/BRIEF.md
# Write-Only I2C Register Target

This block is an I2C target that only accepts write transfers. It samples SCL and SDA with the system clock. A controller opens a transfer with START and sends a device address byte. If that byte matches and its read/write bit is zero, the controller then sends a subaddress byte, followed by any number of data bytes. The block acknowledges every byte it accepts. Each data byte leaves the block as a write strobe that lasts one system clock and carries a register address and the data. After each byte the register pointer advances by one, so a burst fills consecutive registers.

The device address comes from a board strap with three levels: tied low, left open or tied high. The strap reaches the block already encoded as a 2-bit code. The block drives the shared data line only through an active-high pull-low enable. A wired-AND bus model outside the block combines that enable with the controller's drive.

Top module: `i2c_wr_slave`

## Requirements
- R1: The strap code picks the 8-bit address byte, with the read/write bit in bit 0. Code 2'b00 selects 0xD6, 2'b01 selects 0xDC, 2'b10 selects 0xDE, and the reserved code 2'b11 behaves like 2'b00.
- R2: A matching address byte with bit 0 clear is acknowledged. The block pulls SDA low after the eighth falling SCL edge of the byte and releases it after the ninth.
- R3: An address byte that does not match, or that has bit 0 set (a read), gets no acknowledge. Every later byte up to the next START is then ignored: no acknowledge and no write strobe.
- R4: The byte after an accepted address is the subaddress and is acknowledged. Its low ADDR_W bits (5 by default) load the register pointer, and its upper bits are ignored.
- R5: Every data byte is received MSB first and acknowledged. It produces exactly one write strobe, one system clock wide, carrying the current pointer and the byte.
- R6: After each stored byte the pointer increments, wrapping from 31 back to 0 with the default 32 registers.
- R7: A STOP (SDA rising while SCL is high) at any point ends the transfer and releases SDA. A partly received byte is discarded without a write.
- R8: A START seen in the middle of a transfer aborts the byte in progress. Reception restarts at the device address.
- R9: After reset the pull-low enable and the write strobe are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_i | input | 2 | Encoded address strap (00 low, 01 open, 10 high) |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| wr_en_o | output | 1 | One-clock register write strobe |
| wr_addr_o | output | ADDR_W | Register address for the strobe |
| wr_data_o | output | 8 | Data byte for the strobe |

## Verification
Three events share one system clock: the write strobe for a data byte, the start of the acknowledge drive, and the step of the register pointer, including its wrap from the last register to register 0. Bursts that begin at register 30, and one 33-byte burst that runs all the way around the file, force the strobe for register 31 to land in the same cycle as the wrap. Each burst is judged by the logged sequence of strobe addresses and data, which is compared with values computed from the start pointer and a data formula, and by the acknowledge level sampled at the ninth SCL high of every byte.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_DEV  = 2'd1,
      PH_SUB  = 2'd2,
      PH_DATA = 2'd3
   } phase_e;
endpackage

// File: rtl/i2c_wr_sync.sv
// Two-stage (parameterised) synchroniser plus bus-edge and START/STOP detection.
module i2c_wr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_q;
   logic [STAGES-1:0] sda_q;
   logic              scl_d;
   logic              sda_d;
   logic              scl_s;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_q <= '1;
               sda_q <= '1;
            end else begin
               scl_q <= scl_i;
               sda_q <= sda_i;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_q <= '1;
               sda_q <= '1;
            end else begin
               scl_q <= {scl_q[STAGES-2:0], scl_i};
               sda_q <= {sda_q[STAGES-2:0], sda_i};
            end
         end
      end
   endgenerate

   assign scl_s = scl_q[STAGES-1];
   assign sda_s = sda_q[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_wr_addr_sel.sv
// Maps the encoded strap to the device address byte; optional register stage.
module i2c_wr_addr_sel #(
   parameter logic [7:0] ADDR_LOW  = 8'hD6,
   parameter logic [7:0] ADDR_OPEN = 8'hDC,
   parameter logic [7:0] ADDR_HIGH = 8'hDE,
   parameter bit         REG_STRAP = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] strap_i,
   output logic [7:0] dev_addr
);
   logic [7:0] pick;

   always_comb begin
      unique case (strap_i)
         2'b01:   pick = ADDR_OPEN;
         2'b10:   pick = ADDR_HIGH;
         default: pick = ADDR_LOW;
      endcase
   end

   generate
      if (REG_STRAP) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dev_addr <= ADDR_LOW;
            else        dev_addr <= pick;
         end
      end else begin : g_comb
         assign dev_addr = pick;
      end
   endgenerate
endmodule

// File: rtl/i2c_wr_engine.sv
// Byte engine: shifts bits, judges each byte, drives ack and the write strobe.
module i2c_wr_engine
   import i2c_wr_pkg::*;
#(
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [7:0]        dev_addr,
   output logic              sda_oe,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data
);
   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

   phase_e            phase;
   logic [CNT_W-1:0]  bitcnt;
   logic [7:0]        shreg;
   logic              ack_ph;
   logic [ADDR_W-1:0] ptr;
   logic              dev_hit;

   assign dev_hit = (shreg[7:1] == dev_addr[7:1]) && !shreg[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         bitcnt  <= '0;
         shreg   <= '0;
         ack_ph  <= 1'b0;
         ptr     <= '0;
         sda_oe  <= 1'b0;
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_det) begin
            phase  <= PH_DEV;
            bitcnt <= '0;
            ack_ph <= 1'b0;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            phase  <= PH_IDLE;
            bitcnt <= '0;
            ack_ph <= 1'b0;
            sda_oe <= 1'b0;
         end else if (phase != PH_IDLE) begin
            if (scl_rise && !ack_ph && bitcnt != FULL) begin
               shreg  <= {shreg[6:0], sda_s};
               bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
               if (ack_ph) begin
                  ack_ph <= 1'b0;
                  sda_oe <= 1'b0;
                  bitcnt <= '0;
                  if (phase == PH_DEV)      phase <= PH_SUB;
                  else if (phase == PH_SUB) phase <= PH_DATA;
               end else if (bitcnt == FULL) begin
                  unique case (phase)
                     PH_DEV: begin
                        if (dev_hit) begin
                           ack_ph <= 1'b1;
                           sda_oe <= 1'b1;
                        end else begin
                           phase <= PH_IDLE;
                        end
                     end
                     PH_SUB: begin
                        ptr    <= shreg[ADDR_W-1:0];
                        ack_ph <= 1'b1;
                        sda_oe <= 1'b1;
                     end
                     PH_DATA: begin
                        wr_en   <= 1'b1;
                        wr_addr <= ptr;
                        wr_data <= shreg;
                        ptr     <= ptr + 1'b1;
                        ack_ph  <= 1'b1;
                        sda_oe  <= 1'b1;
                     end
                     default: phase <= PH_IDLE;
                  endcase
               end
            end
         end
      end
   end
endmodule

// File: rtl/i2c_wr_slave.sv
module i2c_wr_slave #(
   parameter int         ADDR_W      = 5,
   parameter int         SYNC_STAGES = 2,
   parameter bit         REG_STRAP   = 1'b0,
   parameter logic [7:0] ADDR_LOW    = 8'hD6,
   parameter logic [7:0] ADDR_OPEN   = 8'hDC,
   parameter logic [7:0] ADDR_HIGH   = 8'hDE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [1:0]        strap_i,
   output logic              sda_oe_o,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [7:0]        wr_data_o
);
   initial begin
      if (ADDR_W < 1 || ADDR_W > 8)
         $fatal(1, "ADDR_W must lie in 1..8");
      if (SYNC_STAGES < 1)
         $fatal(1, "SYNC_STAGES must be at least 1");
      if (ADDR_LOW[0] || ADDR_OPEN[0] || ADDR_HIGH[0])
         $fatal(1, "device address bytes need bit 0 clear");
   end

   logic       sda_s;
   logic       scl_rise;
   logic       scl_fall;
   logic       start_det;
   logic       stop_det;
   logic [7:0] dev_addr;

   i2c_wr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_wr_addr_sel #(
      .ADDR_LOW  (ADDR_LOW),
      .ADDR_OPEN (ADDR_OPEN),
      .ADDR_HIGH (ADDR_HIGH),
      .REG_STRAP (REG_STRAP)
   ) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .strap_i  (strap_i),
      .dev_addr (dev_addr)
   );

   i2c_wr_engine #(.ADDR_W(ADDR_W)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .dev_addr  (dev_addr),
      .sda_oe    (sda_oe_o),
      .wr_en     (wr_en_o),
      .wr_addr   (wr_addr_o),
      .wr_data   (wr_data_o)
   );
endmodule

// File: rtl/i2c_wr_slave_chk.sv
module i2c_wr_slave_chk #(
   parameter int         ADDR_W    = 5,
   parameter logic [7:0] ADDR_LOW  = 8'hD6,
   parameter logic [7:0] ADDR_OPEN = 8'hDC,
   parameter logic [7:0] ADDR_HIGH = 8'hDE
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        strap_i,
   input logic [7:0]        dev_addr,
   input logic              start_det,
   input logic              stop_det,
   input logic              sda_oe,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr
);
   logic              have_prev;
   logic [ADDR_W-1:0] prev_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_prev <= 1'b0;
         prev_addr <= '0;
      end else if (start_det || stop_det) begin
         have_prev <= 1'b0;
      end else if (wr_en) begin
         have_prev <= 1'b1;
         prev_addr <= wr_addr;
      end
   end

   // R1
   strap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((strap_i == 2'b00 || strap_i == 2'b11) && $stable(strap_i)) |-> dev_addr == ADDR_LOW);

   // R1
   strap_open_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strap_i[0] != strap_i[1] && $stable(strap_i)) |->
         dev_addr == (strap_i[0] ? ADDR_OPEN : ADDR_HIGH));

   // R5
   strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   // R5
   strobe_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> sda_oe);

   // R6
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && have_prev) |-> wr_addr == ADDR_W'(prev_addr + 1'b1));

   // R7
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe && !wr_en);

   // R8
   start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !sda_oe && !wr_en);
endmodule

bind i2c_wr_slave i2c_wr_slave_chk #(
   .ADDR_W    (ADDR_W),
   .ADDR_LOW  (ADDR_LOW),
   .ADDR_OPEN (ADDR_OPEN),
   .ADDR_HIGH (ADDR_HIGH)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .strap_i   (strap_i),
   .dev_addr  (dev_addr),
   .start_det (start_det),
   .stop_det  (stop_det),
   .sda_oe    (sda_oe_o),
   .wr_en     (wr_en_o),
   .wr_addr   (wr_addr_o)
);

// File: tb/tb_i2c_wr_slave.sv
`timescale 1ns/1ps
module tb_i2c_wr_slave;
   localparam int ADDR_W = 5;
   localparam int NREG   = 1 << ADDR_W;
   localparam int Q      = 6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              scl = 1'b1;
   logic              m_sda = 1'b1;
   logic [1:0]        strap = 2'b00;
   logic              sda_oe;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [7:0]        wr_data;
   wire               sda_line = m_sda & ~sda_oe;

   int total = 0;
   int bad   = 0;
   int log_n = 0;
   int log_addr [0:63];
   int log_data [0:63];

   always #5 clk = ~clk;

   i2c_wr_slave dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl),
      .sda_i     (sda_line),
      .strap_i   (strap),
      .sda_oe_o  (sda_oe),
      .wr_en_o   (wr_en),
      .wr_addr_o (wr_addr),
      .wr_data_o (wr_data)
   );

   always @(negedge clk) begin
      if (wr_en && log_n < 64) begin
         log_addr[log_n] = int'(wr_addr);
         log_data[log_n] = int'(wr_data);
         log_n = log_n + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_q(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic i2c_start();
      m_sda = 1'b1; wait_q(Q);
      scl = 1'b1;   wait_q(Q);
      m_sda = 1'b0; wait_q(Q);
      scl = 1'b0;   wait_q(Q);
   endtask

   task automatic i2c_stop();
      m_sda = 1'b0; wait_q(Q);
      scl = 1'b1;   wait_q(Q);
      m_sda = 1'b1; wait_q(2 * Q);
   endtask

   task automatic send_bits(input logic [7:0] b, input int nb);
      for (int i = 7; i > 7 - nb; i--) begin
         m_sda = b[i]; wait_q(Q);
         scl = 1'b1;   wait_q(2 * Q);
         scl = 1'b0;   wait_q(Q);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      send_bits(b, 8);
      m_sda = 1'b1; wait_q(Q);
      scl = 1'b1;   wait_q(Q);
      acked = (sda_line == 1'b0);
      wait_q(Q);
      scl = 1'b0;   wait_q(Q);
   endtask

   function automatic logic [7:0] dat(input int seed, input int k);
      return 8'((seed * 37 + k * 11 + 5) & 8'hFF);
   endfunction

   function automatic logic [7:0] addr_of(input int code);
      case (code)
         1:       return 8'hDC;
         2:       return 8'hDE;
         default: return 8'hD6;
      endcase
   endfunction

   task automatic xfer(input logic [7:0] dev, input logic [7:0] sub, input int n,
                       input int seed, output int acks);
      bit a;
      acks = 0;
      log_n = 0;
      i2c_start();
      send_byte(dev, a); acks += int'(a);
      send_byte(sub, a); acks += int'(a);
      for (int k = 0; k < n; k++) begin
         send_byte(dat(seed, k), a);
         acks += int'(a);
      end
      i2c_stop();
      chk(sda_oe == 1'b0, "R2 release", int'(sda_oe), 0);
   endtask

   task automatic chk_log(input int start, input int n, input int seed, input string req);
      chk(log_n == n, req, log_n, n);
      for (int k = 0; k < n && k < log_n; k++) begin
         chk(log_addr[k] == (start + k) % NREG, req, log_addr[k], (start + k) % NREG);
         chk(log_data[k] == int'(dat(seed, k)), req, log_data[k], int'(dat(seed, k)));
      end
   endtask

   task automatic report();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", 1, 0);
      report();
      $finish;
   end

   initial begin
      int acks;
      bit a;
      wait_q(4);
      // R9: reset state
      chk(sda_oe == 1'b0, "R9 sda_oe", int'(sda_oe), 0);
      chk(wr_en == 1'b0, "R9 wr_en", int'(wr_en), 0);
      rst_n = 1'b1;
      wait_q(4);

      // R1 R2 R3 R5: sweep every strap code against every candidate address
      for (int s = 0; s < 4; s++) begin
         strap = 2'(s);
         wait_q(4);
         xfer(addr_of(s), 8'(s * 5), 3, s, acks);
         chk(acks == 5, "R1 R2 match ack", acks, 5);
         chk_log(s * 5, 3, s, "R5 data");
         for (int o = 0; o < 3; o++) begin
            if (addr_of(o) != addr_of(s)) begin
               xfer(addr_of(o), 8'h01, 2, 9, acks);
               chk(acks == 0, "R3 mismatch ack", acks, 0);
               chk(log_n == 0, "R3 mismatch write", log_n, 0);
            end
         end
         xfer(addr_of(s) | 8'h01, 8'h02, 2, 3, acks);
         chk(acks == 0, "R3 read bit", acks, 0);
         chk(log_n == 0, "R3 read write", log_n, 0);
      end

      strap = 2'b00;
      wait_q(4);
      // R6: wrap from the last register
      xfer(8'hD6, 8'd30, 4, 11, acks);
      chk(acks == 6, "R6 ack", acks, 6);
      chk_log(30, 4, 11, "R6 wrap");

      // R4: upper subaddress bits ignored
      xfer(8'hD6, 8'hE3, 2, 12, acks);
      chk(acks == 4, "R4 ack", acks, 4);
      chk_log(3, 2, 12, "R4 sub");

      // R6: burst longer than the register file
      xfer(8'hD6, 8'd7, 33, 13, acks);
      chk(acks == 35, "R6 long ack", acks, 35);
      chk_log(7, 33, 13, "R6 long");

      // R7: stop in the middle of a data byte
      log_n = 0;
      i2c_start();
      send_byte(8'hD6, a);
      send_byte(8'd4, a);
      send_byte(dat(14, 0), a);
      send_bits(8'hA5, 4);
      i2c_stop();
      chk(log_n == 1, "R7 partial", log_n, 1);
      chk(sda_oe == 1'b0, "R7 release", int'(sda_oe), 0);
      chk(log_n > 0 && log_addr[0] == 4, "R7 addr", log_addr[0], 4);

      // R8: repeated start mid byte restarts address reception
      log_n = 0;
      i2c_start();
      send_byte(8'hD6, a);
      send_byte(8'd20, a);
      send_bits(8'h3C, 3);
      i2c_start();
      send_byte(8'hD6, a);
      chk(a == 1'b1, "R8 readdress ack", int'(a), 1);
      send_byte(8'd9, a);
      send_byte(8'h5A, a);
      i2c_stop();
      chk(log_n == 1, "R8 count", log_n, 1);
      chk(log_n > 0 && log_addr[0] == 9, "R8 addr", log_addr[0], 9);
      chk(log_n > 0 && log_data[0] == 8'h5A, "R8 data", log_data[0], 8'h5A);

      // R3: bytes after a mismatch stay ignored even if they look like the address
      log_n = 0;
      i2c_start();
      send_byte(8'hDE, a);
      chk(a == 1'b0, "R3 nack", int'(a), 0);
      send_byte(8'hD6, a);
      chk(a == 1'b0, "R3 ignored", int'(a), 0);
      send_byte(8'h11, a);
      i2c_stop();
      chk(log_n == 0, "R3 no write", log_n, 0);

      report();
      $finish;
   end
endmodule